// File: doc/BRIEF.md
# Dual-Mode FIFO Threshold Interrupt Controller

This block buffers converter samples in a first-in first-out store and raises an interrupt flag once the number of buffered samples reaches a programmable fill level. Samples enter through a one-cycle write strobe. The host pops them through a show-ahead read port, where the oldest sample is always visible while the store is not empty. A byte-wide register sets the fill level, and one register read address returns a status byte.

A mode input selects how the register is used. In basic mode the register holds a small level of 1 to 48, the store holds 48 samples, and reading the register echoes the level. In enhanced mode the byte is a coarse level in units of eight (8 to 2048), the store holds 2048 samples, and reading the register returns the low byte of the live sample count. The first entry into enhanced mode after reset presets the level to 1024. A clear pulse resets both the interrupt flag and a sticky overflow flag, which records samples dropped while the store was full.

Top module: `fifo_thresh_irq`

## Requirements
- R1: In basic mode (mode_i = 0) a register write keeps only wdata bits 5..0, stores 0 as 1 and any value above 48 as 48. The register read returns the stored 6-bit value in bits 5..0, with bits 7..6 zero. The effective basic level is the stored value clamped to 1..48, so the reset value 0 acts as 1.
- R2: In enhanced mode (mode_i = 1) a written byte B sets the level to B*8, and B = 0 sets it to 2048.
- R3: The first 0-to-1 transition of mode_i after reset loads the register with 128, which is a level of 1024. Later 0-to-1 transitions keep the register's value, and only reset re-arms the preset.
- R4: In enhanced mode the register read returns bits 7..0 of the current sample count.
- R5: After reset the register reads 0, irq_o and ovf_o are 0 and empty_o is 1.
- R6: irq_o goes high in the cycle after a sample write strobe for which the resulting count (after that cycle's push and pop) is at or above the current level. This applies whether the sample was stored or dropped.
- R7: irq_o stays high until irq_clr_i. A clear drops it in the next cycle, unless a write in the same cycle meets R6, in which case it stays high.
- R8: Samples pop in write order. The capacity is 48 in basic mode and 2048 in enhanced mode. A pop while empty_o is 1 has no effect.
- R9: A sample write while the count is at capacity is dropped, even if a pop happens in the same cycle, and sets ovf_o in the next cycle. ovf_o stays high until irq_clr_i, and a dropped write in the same cycle as the clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 1 | 0 selects basic mode, 1 selects enhanced mode |
| samp_valid_i | input | 1 | Sample write strobe |
| samp_data_i | input | DATA_W | Sample value |
| pop_i | input | 1 | Pop the oldest sample |
| pop_data_o | output | DATA_W | Oldest sample (valid while empty_o is 0) |
| empty_o | output | 1 | Store holds no sample |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write byte |
| reg_rdata_o | output | 8 | Register read byte (level echo or count low byte) |
| irq_clr_i | input | 1 | Clears irq_o and ovf_o |
| irq_o | output | 1 | Fill level reached |
| ovf_o | output | 1 | Sticky sample-dropped flag |

## Verification
The hardest states to reach are the enhanced-mode extremes: a level of 2048 written as byte 0, the store completely full at 2048 entries, and a second mode entry that must not repeat the 1024 preset. The stimulus gets there by running long push loops in enhanced mode. First it fills to the 1024 preset, then it writes byte 0 and fills to 2048 with one extra dropped write. Then it drains, toggles the mode off and on, and fills to the last programmed level. A behavioural queue model follows every cycle, including the cases where a clear and a write fall in the same cycle, or a pop and a write arrive while the store is full.

// File: rtl/fti_pkg.sv
package fti_pkg;
  typedef enum logic {
    MODE_BASIC = 1'b0,
    MODE_ENH   = 1'b1
  } fti_mode_e;
endpackage

// File: rtl/fti_thresh_reg.sv
module fti_thresh_reg
  import fti_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int FIELD_W   = 6,
  parameter int BASIC_MAX = 48,
  parameter int SCALE_SH  = 3,
  parameter int AUTO_CODE = 128,
  parameter int THR_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fti_mode_e        mode,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] reg_q_o,
  output logic [THR_W-1:0] thr_o
);
  localparam int PAD_W = REG_W - FIELD_W;
  localparam logic [THR_W-1:0] ENH_MAX = THR_W'(1 << (REG_W + SCALE_SH));

  function automatic logic [FIELD_W-1:0] clamp_field(input logic [FIELD_W-1:0] v);
    if (v == '0)                                 return FIELD_W'(1);
    else if (32'(v) > BASIC_MAX)                 return FIELD_W'(BASIC_MAX);
    else                                         return v;
  endfunction

  logic [REG_W-1:0] reg_q, reg_d;
  logic             reg_en;
  logic             seen_q, seen_d;
  logic             mode_q;
  logic             rise;

  // next state
  always_comb begin
    rise   = (mode == MODE_ENH) && !mode_q;
    seen_d = seen_q | rise;
    reg_d  = reg_q;
    reg_en = 1'b0;
    if (wr) begin
      reg_en = 1'b1;
      if (mode == MODE_ENH) reg_d = wdata;
      else                  reg_d = {{PAD_W{1'b0}}, clamp_field(wdata[FIELD_W-1:0])};
    end else if (rise && !seen_q) begin
      reg_en = 1'b1;
      reg_d  = REG_W'(AUTO_CODE);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      seen_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (reg_en) reg_q <= reg_d;
      seen_q <= seen_d;
      mode_q <= (mode == MODE_ENH);
    end
  end

  // effective level
  always_comb begin
    if (mode == MODE_ENH) begin
      if (reg_q == '0) thr_o = ENH_MAX;
      else             thr_o = THR_W'(reg_q) << SCALE_SH;
    end else begin
      thr_o = THR_W'(clamp_field(reg_q[FIELD_W-1:0]));
    end
  end

  assign reg_q_o = reg_q;
endmodule

// File: rtl/fti_store.sv
module fti_store
  import fti_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int DEPTH     = 2048,
  parameter int BASIC_CAP = 48,
  parameter int CNT_W     = 12,
  parameter int PTR_W     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fti_mode_e         mode,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  count_next_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count_q, count_d, cap;
  logic              push_ok, pop_ok;

  // next state
  always_comb begin
    cap     = (mode == MODE_ENH) ? CNT_W'(DEPTH) : CNT_W'(BASIC_CAP);
    full_o  = count_q >= cap;
    empty_o = count_q == '0;
    push_ok = push_req && !full_o;
    pop_ok  = pop_req && !empty_o;
    count_d = count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
  end

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok)           wr_ptr  <= ptr_inc(wr_ptr);
      if (pop_ok)            rd_ptr  <= ptr_inc(rd_ptr);
      if (push_ok || pop_ok) count_q <= count_d;
    end
  end

  assign pop_data     = mem[rd_ptr];
  assign count_o      = count_q;
  assign count_next_o = count_d;
endmodule

// File: rtl/fti_flags.sv
module fti_flags #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_valid,
  input  logic             full,
  input  logic [CNT_W-1:0] count_next,
  input  logic [CNT_W-1:0] thr,
  input  logic             clr,
  output logic             irq_o,
  output logic             ovf_o
);
  logic irq_q, irq_d, ovf_q, ovf_d;

  // next state: a new event outranks a clear
  always_comb begin
    irq_d = irq_q;
    ovf_d = ovf_q;
    if (samp_valid && (count_next >= thr)) irq_d = 1'b1;
    else if (clr)                          irq_d = 1'b0;
    if (samp_valid && full)                ovf_d = 1'b1;
    else if (clr)                          ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      ovf_q <= ovf_d;
    end
  end

  assign irq_o = irq_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/fifo_thresh_irq.sv
module fifo_thresh_irq
  import fti_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int DEPTH     = 2048,
  parameter int BASIC_CAP = 48,
  parameter int REG_W     = 8,
  parameter int FIELD_W   = 6,
  parameter int SCALE_SH  = 3,
  parameter int AUTO_THR  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              samp_valid_i,
  input  logic [DATA_W-1:0] samp_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              empty_o,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              irq_clr_i,
  output logic              irq_o,
  output logic              ovf_o
);
  localparam int CNT_W     = $clog2(DEPTH + 1);
  localparam int PTR_W     = $clog2(DEPTH);
  localparam int AUTO_CODE = AUTO_THR >> SCALE_SH;
  localparam int PAD_W     = REG_W - FIELD_W;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  fti_mode_e        mode_e;
  logic [REG_W-1:0] reg_q;
  logic [CNT_W-1:0] thr, count, count_next;
  logic             full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];
  assign mode_e     = fti_mode_e'(mode_i);

  fti_thresh_reg #(
    .REG_W(REG_W), .FIELD_W(FIELD_W), .BASIC_MAX(BASIC_CAP),
    .SCALE_SH(SCALE_SH), .AUTO_CODE(AUTO_CODE), .THR_W(CNT_W)
  ) u_thr (
    .clk(clk), .rst_n(rst_sync_n), .mode(mode_e), .wr(reg_wr_i),
    .wdata(reg_wdata_i), .reg_q_o(reg_q), .thr_o(thr)
  );

  fti_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .BASIC_CAP(BASIC_CAP),
    .CNT_W(CNT_W), .PTR_W(PTR_W)
  ) u_store (
    .clk(clk), .rst_n(rst_sync_n), .mode(mode_e), .push_req(samp_valid_i),
    .push_data(samp_data_i), .pop_req(pop_i), .pop_data(pop_data_o),
    .count_o(count), .count_next_o(count_next), .full_o(full), .empty_o(empty_o)
  );

  fti_flags #(.CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .samp_valid(samp_valid_i), .full(full),
    .count_next(count_next), .thr(thr), .clr(irq_clr_i),
    .irq_o(irq_o), .ovf_o(ovf_o)
  );

  assign reg_rdata_o = (mode_e == MODE_ENH) ? count[REG_W-1:0]
                                            : {{PAD_W{1'b0}}, reg_q[FIELD_W-1:0]};
endmodule

// File: rtl/fti_checker.sv
module fti_checker #(
  parameter int DEPTH     = 2048,
  parameter int BASIC_CAP = 48,
  parameter int CNT_W     = 12,
  parameter int REG_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_i,
  input logic             samp_valid_i,
  input logic             pop_i,
  input logic             reg_wr_i,
  input logic             irq_clr_i,
  input logic             irq_o,
  input logic             ovf_o,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             full,
  input logic [CNT_W-1:0] count
);
  assert_basic_clamp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && reg_wr_i) |=> (mode_i || ((reg_rdata_o[5:0] >= 6'd1) &&
                                          (reg_rdata_o[5:0] <= 6'(BASIC_CAP)))));

  assert_depth_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && samp_valid_i && !full && !pop_i) |=>
      (!mode_i || (reg_rdata_o == $past(reg_rdata_o) + 8'd1)));

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(samp_valid_i));

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(samp_valid_i && full));

  assert_ovf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !irq_clr_i) |=> ovf_o);
endmodule

bind fifo_thresh_irq fti_checker #(
  .DEPTH(DEPTH), .BASIC_CAP(BASIC_CAP), .CNT_W(CNT_W), .REG_W(REG_W)
) u_fti_checker (
  .clk(clk), .rst_n(rst_sync_n), .mode_i(mode_i), .samp_valid_i(samp_valid_i),
  .pop_i(pop_i), .reg_wr_i(reg_wr_i), .irq_clr_i(irq_clr_i), .irq_o(irq_o),
  .ovf_o(ovf_o), .reg_rdata_o(reg_rdata_o), .full(full), .count(count)
);

// File: tb/fifo_thresh_irq_bench.sv
`timescale 1ns/1ps
module fifo_thresh_irq_bench;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0;
  logic          sv = 1'b0, pop = 1'b0, wr = 1'b0, clr = 1'b0;
  logic [DW-1:0] sd = '0;
  logic [7:0]    wd = '0;
  logic [DW-1:0] pop_data;
  logic          empty, irq, ovf;
  logic [7:0]    rdata;

  fifo_thresh_irq u_fifo_thresh_irq (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .samp_valid_i(sv),
    .samp_data_i(sd), .pop_i(pop), .pop_data_o(pop_data), .empty_o(empty),
    .reg_wr_i(wr), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .irq_clr_i(clr), .irq_o(irq), .ovf_o(ovf)
  );

  always #4 clk = ~clk;

  int    n_checks = 0, n_fail = 0;
  string cur_req = "R5";
  bit    cmp_en = 1'b0;
  bit    done = 1'b0;

  // behavioural model
  int m_reg, m_seen, m_modeq, m_irq, m_ovf;
  int q[$];
  int next_val = 1;

  function automatic int clamp6(int v);
    if (v == 0) return 1;
    if (v > 48) return 48;
    return v;
  endfunction

  function automatic int level(int md, int r);
    if (md != 0) return (r == 0) ? 2048 : r * 8;
    return clamp6(r & 63);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 0; m_seen = 0; m_modeq = 0; m_irq = 0; m_ovf = 0;
      q.delete();
    end else begin
      int  thr, cap, sz, nc;
      bit  full, push_ok, pop_ok, rise;
      thr     = level(mode, m_reg);
      cap     = mode ? 2048 : 48;
      sz      = q.size();
      full    = sz >= cap;
      push_ok = sv && !full;
      pop_ok  = pop && (sz > 0);
      nc      = sz + int'(push_ok) - int'(pop_ok);
      if (sv && nc >= thr) m_irq = 1; else if (clr) m_irq = 0;
      if (sv && full)      m_ovf = 1; else if (clr) m_ovf = 0;
      rise = mode && (m_modeq == 0);
      if (wr) m_reg = mode ? int'(wd) : clamp6(int'(wd) & 63);
      else if (rise && m_seen == 0) m_reg = 128;
      if (rise) m_seen = 1;
      m_modeq = mode;
      if (pop_ok)  void'(q.pop_front());
      if (push_ok) q.push_back(int'(sd));
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      int exp_rd;
      exp_rd = mode ? (q.size() & 255) : (m_reg & 63);
      check(irq == m_irq[0], cur_req, "irq_o", int'(irq), m_irq);
      check(ovf == m_ovf[0], (cur_req == "R5") ? "R5" : "R9", "ovf_o", int'(ovf), m_ovf);
      check(int'(rdata) == exp_rd, (cur_req == "R5") ? "R5" : (mode ? "R4" : "R1"),
            "reg_rdata_o", int'(rdata), exp_rd);
      check(empty == (q.size() == 0), (cur_req == "R5") ? "R5" : "R8", "empty_o",
            int'(empty), int'(q.size() == 0));
      if (q.size() > 0)
        check(int'(pop_data) == q[0], "R8", "pop_data_o", int'(pop_data), q[0]);
    end
  end

  // one cycle of stimulus, pulses released afterwards
  task automatic step(input bit s, input bit p, input bit w, input int d, input bit c);
    sv = s; pop = p; wr = w; wd = 8'(d); clr = c;
    if (s) begin sd = DW'(next_val); next_val = (next_val * 7 + 3) % 4096; end
    @(posedge clk); #2;
    sv = 0; pop = 0; wr = 0; clr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0);
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) step(0, 1, 0, 0, 0);
  endtask

  task automatic set_mode(input bit m);
    mode = m;
    idle(1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 cmp_en = 1'b1;
    idle(1);
    rst_n = 1'b1;
    idle(4);

    // R6: reset level 0 acts as 1
    cur_req = "R6";
    push_n(1);
    step(0, 1, 0, 0, 1);
    idle(1);

    // R1: clamping and field selection
    cur_req = "R1";
    step(0, 0, 1, 8'h00, 0); idle(1);
    step(0, 0, 1, 8'hFF, 0); idle(1);
    step(0, 0, 1, 8'h31, 0); idle(1);
    step(0, 0, 1, 8'h30, 0); idle(1);
    step(0, 0, 1, 8'hC5, 0); idle(1);

    // R6 / R7 with level 5
    cur_req = "R6";
    push_n(4); idle(1);
    push_n(1); idle(2);
    cur_req = "R7";
    step(0, 0, 0, 0, 1); idle(1);
    push_n(1); idle(1);
    step(1, 0, 0, 0, 1); idle(1);
    step(0, 0, 0, 0, 1); idle(1);

    // R8: order, pop while empty
    cur_req = "R8";
    pop_n(7); idle(1);
    step(1, 1, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    pop_n(2);

    // R9: basic capacity 48
    cur_req = "R9";
    step(0, 0, 1, 48, 0);
    push_n(48); idle(1);
    step(1, 1, 0, 0, 0);
    push_n(2); idle(1);
    step(1, 0, 0, 0, 1); idle(1);
    step(0, 0, 0, 0, 1); idle(1);
    pop_n(50);
    step(0, 0, 0, 0, 1);

    // R3: first entry presets 1024
    cur_req = "R3";
    set_mode(1);
    push_n(1023); idle(1);
    push_n(1); idle(1);
    step(0, 0, 0, 0, 1);

    // R4: depth byte while popping
    cur_req = "R4";
    pop_n(4);
    step(1, 1, 0, 0, 0);

    // R2: byte 0 means 2048, full enhanced store
    cur_req = "R2";
    step(0, 0, 1, 8'h00, 0);
    push_n(1027); idle(1);
    push_n(1); idle(1);
    cur_req = "R9";
    step(0, 0, 0, 0, 1);
    push_n(1); idle(1);
    step(1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    cur_req = "R2";
    step(0, 0, 1, 8'h02, 0);
    pop_n(2049);

    // R3: second entry keeps 16
    cur_req = "R3";
    set_mode(0); idle(1);
    set_mode(1);
    push_n(15); idle(1);
    push_n(1); idle(1);
    step(0, 0, 0, 0, 1);
    cur_req = "R2";
    step(0, 0, 1, 8'h01, 0);
    pop_n(10);
    push_n(1); idle(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL %s watchdog expired: actual 0 expected 1", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule